// File: doc/BRIEF.md
# Burst-Limited Pulse Repetition Controller

This block turns rising edges on an asynchronous trigger line into output pulses of fixed width. It limits how often those pulses may repeat, so that the output stage downstream never overheats. A width switch asks for either a long pulse or a short pulse. The long pulse runs under a hard minimum spacing between accepted pulses. The short pulse runs in a burst regime. In that regime pulses may come much faster than the continuous limit for a bounded stretch of time. A leaky credit counter then starts refusing triggers, which pulls the average rate back down to a safe figure.

The burst regime is offered only to hardware that reports a new enough board identity. A 6-bit identity word carries a 4-bit version in its upper bits and a 2-bit revision in its lower bits. A version below the threshold, including an all-zero word from a board that cannot identify itself, forces long-pulse operation whatever the switch says. The switch and the identity word are captured while reset is held, and they are frozen afterwards.

Every trigger edge that does not become a pulse raises a one-cycle missed strobe and advances a saturating count of missed triggers.

The controller is a three-state machine:
- `ST_READY`: idle, and a pulse may start.
- `ST_FIRE`: the output is high.
- `ST_GUARD`: long-pulse hold-off until the minimum spacing has elapsed.

Its transitions are:
- READY to FIRE on an accepted edge.
- FIRE to GUARD at the end of a long pulse.
- FIRE to READY at the end of a short pulse.
- GUARD to FIRE when an edge lands on the last hold-off cycle.
- GUARD to READY when the hold-off expires with no edge.

Top module: `burst_pulse_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `pulse_out` and `missed_strobe` are 0 and `missed_count` is 0.
- R2: An accepted pulse keeps `pulse_out` high for exactly LONG_W cycles in long mode, or exactly SHORT_W cycles in burst mode, and then low.
- R3: In long mode, a pulse may start at the earliest MIN_GAP clock edges after the edge that started the previous pulse. An edge arriving sooner is dropped.
- R4: In burst mode, a trigger edge is accepted when more than SHORT_W edges have passed since the last accepted one and the credit is below BURST_PULSES*BURST_COST. Credit starts at 0. On every edge it falls by 1 (not below 0), and each burst-mode acceptance adds BURST_COST on the same edge.
- R5: Burst mode is selected only if `width_sel` is 1 and the version field `board_id[5:2]` is at least MIN_VERSION (default 4). The revision bits `board_id[1:0]` have no influence on the mode. Otherwise the block runs in long mode.
- R6: A `board_id[5:2]` of 0 always gives long mode, even with `width_sel` = 1.
- R7: `width_sel` and `board_id` are sampled only while `rst_n` is low. Changes after reset do not alter the mode.
- R8: A trigger edge that arrives while a pulse is being output is dropped. It neither stretches nor restarts the pulse.
- R9: Every dropped trigger edge gives a one-cycle `missed_strobe` on the same edge that a pulse would have started. On that same edge `missed_count` increases by 1, saturating at 2^CNT_W-1.
- R10: `trig_in` passes two synchronizing flops and a rising-edge detector. A rising edge driven before clock edge k starts a pulse at edge k+2, and a held-high level starts nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode inputs are captured while low |
| trig_in | input | 1 | Asynchronous trigger line, rising edge requests a pulse |
| width_sel | input | 1 | 1 requests short pulses and burst operation, 0 long pulses |
| board_id | input | 6 | Board identity: [5:2] version, [1:0] revision |
| pulse_out | output | 1 | Output pulse |
| missed_strobe | output | 1 | One-cycle flag for each dropped trigger edge |
| missed_count | output | CNT_W | Saturating count of dropped trigger edges |

## Verification
A trigger level driven before clock edge k appears as a pulse or a missed strobe after edge k+2: two edges of synchronizer, then the registered decision. The bench therefore carries a behavioural model that shifts the sampled trigger through the same two-edge delay. At each rising edge the model computes the edge's outcome from integer ages and credit. It compares all three outputs on the following falling edge. Directed checks count negative edges from the trigger write in the same way. The pulse is expected low on the first two falling edges and high on the third, and its width is measured from that point.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_FIRE  = 2'd1,
        ST_GUARD = 2'd2
    } bpc_state_e;

    // Version in the upper four bits, revision below: comparing the whole
    // word against {min_version, 2'b00} is a version-only comparison.
    function automatic logic burst_capable(input logic [5:0] id,
                                           input logic [3:0] min_version);
        return id >= {min_version, 2'b00};
    endfunction

endpackage

// File: rtl/bpc_edge_sync.sv
module bpc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // sh[0 .. STAGES-1] synchronize, sh[STAGES] holds the previous level
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], din};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/bpc_credit.sv
module bpc_credit #(
    parameter int unsigned COST = 24097,
    parameter int unsigned CEIL = 963880
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic charge,
    output logic room
);
    localparam int unsigned CW = $clog2(CEIL + COST + 1);

    logic [CW-1:0] credit;
    logic [CW-1:0] drained;

    always_comb begin
        drained = (credit != '0) ? credit - CW'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit <= '0;
        end else if (enable && charge) begin
            credit <= drained + CW'(COST);
        end else begin
            credit <= drained;
        end
    end

    assign room = credit < CW'(CEIL);
endmodule

// File: rtl/bpc_miss_count.sv
module bpc_miss_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    output logic             strobe,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            count  <= '0;
        end else begin
            strobe <= drop;
            if (drop && (count != '1)) begin
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/burst_pulse_ctrl.sv
module burst_pulse_ctrl
    import bpc_pkg::*;
#(
    parameter int unsigned LONG_W       = 120,
    parameter int unsigned SHORT_W      = 25,
    parameter int unsigned MIN_GAP      = 24097,
    parameter int unsigned BURST_COST   = 24097,
    parameter int unsigned BURST_PULSES = 40,
    parameter int unsigned MIN_VERSION  = 4,
    parameter int unsigned CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             width_sel,
    input  logic [5:0]       board_id,
    output logic             pulse_out,
    output logic             missed_strobe,
    output logic [CNT_W-1:0] missed_count
);
    localparam int unsigned    TW      = $clog2(MIN_GAP + 1);
    localparam int unsigned    CEIL    = BURST_PULSES * BURST_COST;
    localparam logic [3:0]     MIN_VER = 4'(MIN_VERSION);
    localparam logic [TW-1:0]  GAP_END = TW'(MIN_GAP - 1);

    bpc_state_e    state, nxt;
    logic          mode_short;
    logic          rise, room, accept, drop;
    logic [TW-1:0] since, len_end;

    // mode capture, only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_short <= width_sel && burst_capable(board_id, MIN_VER);
        end
    end

    bpc_edge_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .rise (rise)
    );

    bpc_credit #(.COST(BURST_COST), .CEIL(CEIL)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(mode_short),
        .charge(accept),
        .room  (room)
    );

    bpc_miss_count #(.CNT_W(CNT_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (drop),
        .strobe(missed_strobe),
        .count (missed_count)
    );

    assign len_end = mode_short ? TW'(SHORT_W - 1) : TW'(LONG_W - 1);

    // next state and acceptance decision
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_READY: begin
                if (rise && (!mode_short || room)) begin
                    accept = 1'b1;
                    nxt    = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (since == len_end) begin
                    nxt = mode_short ? ST_READY : ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (since == GAP_END) begin
                    if (rise) begin
                        accept = 1'b1;
                        nxt    = ST_FIRE;
                    end else begin
                        nxt = ST_READY;
                    end
                end
            end
            default: nxt = ST_READY;
        endcase
    end

    assign drop = rise && !accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= nxt;
        end
    end

    // outputs and elapsed-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            since     <= '0;
        end else begin
            pulse_out <= (nxt == ST_FIRE);
            if (accept) begin
                since <= '0;
            end else if (state != ST_READY) begin
                since <= since + TW'(1);
            end
        end
    end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int unsigned LONG_W  = 120,
    parameter int unsigned SHORT_W = 25,
    parameter int unsigned MIN_GAP = 24097,
    parameter int unsigned CNT_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pulse_out,
    input logic             missed_strobe,
    input logic [CNT_W-1:0] missed_count,
    input logic             mode_short
);
    int unsigned hi_cnt;
    int unsigned gap_cnt;
    logic        pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= 0;
            gap_cnt <= MIN_GAP;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_out;
            hi_cnt  <= pulse_out ? hi_cnt + 1 : 0;
            if (pulse_out && !pulse_q) begin
                gap_cnt <= 1;
            end else if (gap_cnt < MIN_GAP) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    AST_PULSE_NOT_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> hi_cnt < (mode_short ? SHORT_W : LONG_W)); // R2
    AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> hi_cnt == (mode_short ? SHORT_W : LONG_W)); // R2
    AST_LONG_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_out) && !mode_short) |-> gap_cnt >= MIN_GAP); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_out) && mode_short) |-> gap_cnt > SHORT_W); // R8
    AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> !missed_strobe); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_count != $past(missed_count)) |->
            (missed_strobe && missed_count == CNT_W'($past(missed_count) + 1))); // R9
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_short)); // R7
endmodule

bind burst_pulse_ctrl bpc_checker #(
    .LONG_W (LONG_W),
    .SHORT_W(SHORT_W),
    .MIN_GAP(MIN_GAP),
    .CNT_W  (CNT_W)
) u_bpc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulse_out    (pulse_out),
    .missed_strobe(missed_strobe),
    .missed_count (missed_count),
    .mode_short   (mode_short)
);

// File: tb/burst_pulse_ctrl_tb_top.sv
module burst_pulse_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW    = 6;
    localparam int SWD   = 3;
    localparam int GAP   = 40;
    localparam int COST  = 20;
    localparam int NBUR  = 3;
    localparam int CEILV = NBUR * COST;
    localparam int CW    = 3;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int BIG   = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          width_sel = 1'b0;
    logic [5:0]    board_id = 6'd0;
    logic          pulse_out;
    logic          missed_strobe;
    logic [CW-1:0] missed_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    burst_pulse_ctrl #(
        .LONG_W(LW), .SHORT_W(SWD), .MIN_GAP(GAP), .BURST_COST(COST),
        .BURST_PULSES(NBUR), .MIN_VERSION(4), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .width_sel(width_sel),
        .board_id(board_id), .pulse_out(pulse_out),
        .missed_strobe(missed_strobe), .missed_count(missed_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit m_short = 1'b0, s1 = 1'b0, s2 = 1'b0, pv = 1'b0, m_valid = 1'b0;
    int age = BIG, credit = 0, e_cnt = 0;
    bit e_pulse = 1'b0, e_miss = 1'b0;
    int pulse_starts = 0;
    bit last_pulse = 1'b0;

    always @(posedge clk) begin
        bit rise_m, acc;
        if (!rst_n) begin
            m_short = width_sel && (board_id[5:2] >= 4'd4);
            s1 = 0; s2 = 0; pv = 0; age = BIG; credit = 0;
            e_pulse = 0; e_miss = 0; e_cnt = 0; m_valid = 1;
        end else begin
            rise_m = s2 && !pv;
            pv = s2; s2 = s1; s1 = trig_in;
            if (age < BIG) age++;
            acc = 0;
            if (rise_m) acc = m_short ? (age > SWD && credit < CEILV) : (age >= GAP);
            credit = (credit > 0 ? credit - 1 : 0) + ((acc && m_short) ? COST : 0);
            if (acc) age = 0;
            e_pulse = age < (m_short ? SWD : LW);
            e_miss = rise_m && !acc;
            if (e_miss && e_cnt < CMAX) e_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            failures++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R2 pulse_out vs model", int'(pulse_out), int'(e_pulse));
            check("R9 missed_strobe vs model", int'(missed_strobe), int'(e_miss));
            check("R9 missed_count vs model", int'(missed_count), e_cnt);
            if (pulse_out && !last_pulse) pulse_starts++;
            last_pulse = pulse_out;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit sel, input logic [5:0] id);
        @(negedge clk);
        rst_n = 0; width_sel = sel; board_id = id; trig_in = 0;
        idle(3);
        rst_n = 1;
    endtask

    // raise trigger, return measured width; checks R10 latency
    task automatic fire(output int w);
        @(negedge clk); trig_in = 1;
        @(negedge clk);
        check("R10 no pulse after 1 edge", int'(pulse_out), 0);
        @(negedge clk); trig_in = 0;
        check("R10 no pulse after 2 edges", int'(pulse_out), 0);
        @(negedge clk);
        check("R10 pulse after 3rd edge", int'(pulse_out), 1);
        w = 0;
        while (pulse_out && w < 200) begin w++; @(negedge clk); end
    endtask

    task automatic train(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            trig_in = 1; idle(2);
            trig_in = 0; idle(spacing - 2);
        end
    endtask

    initial begin
        int w;
        int c0;
        // R1 reset state
        rst_n = 0; width_sel = 0; board_id = 6'b0100_01;
        idle(3);
        check("R1 pulse in reset", int'(pulse_out), 0);
        check("R1 strobe in reset", int'(missed_strobe), 0);
        check("R1 count in reset", int'(missed_count), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 pulse after reset", int'(pulse_out), 0);
        check("R1 count after reset", int'(missed_count), 0);

        // R2 long width, R7 switch change after reset ignored
        fire(w); check("R2 long width", w, LW);
        width_sel = 1; board_id = 6'b1111_11;
        idle(GAP + 5);
        fire(w); check("R7 width after late switch change", w, LW);
        idle(GAP + 5);

        // R8 trigger during pulse dropped, no stretch
        c0 = int'(missed_count);
        trig_in = 1; idle(2); trig_in = 0; idle(2);
        trig_in = 1; idle(2); trig_in = 0;
        idle(LW + 4);
        check("R8 in-pulse edge counted as missed", int'(missed_count), c0 + 1);
        idle(GAP);

        // R3 long-mode rate limit, R9 saturation
        pulse_starts = 0;
        train(12, 8);
        idle(4);
        check("R3 long-mode starts in 96 cycles", pulse_starts, 3);
        check("R9 missed count saturated", int'(missed_count), CMAX);
        idle(GAP + 5);

        // R5 version 3 with switch on stays long
        do_reset(1, 6'b0011_11);
        fire(w); check("R5 version 3 gives long width", w, LW);
        idle(GAP + 5);

        // R6 unidentified board stays long
        do_reset(1, 6'b0000_00);
        fire(w); check("R6 zero version gives long width", w, LW);
        idle(GAP + 5);

        // R5 version 4 revision 0 with switch on -> burst
        do_reset(1, 6'b0100_00);
        fire(w); check("R5 version 4 gives short width", w, SWD);
        idle(200);

        // R4 burst acceptance beyond continuous rate, then drops
        pulse_starts = 0;
        c0 = int'(missed_count);
        train(12, 8);
        idle(4);
        check_ge("R4 burst starts exceed long limit", pulse_starts, 5);
        check_ge("R4 burst eventually drops", int'(missed_count), c0 + 1);
        idle(300);

        // R4 with switch off on new board: long
        do_reset(0, 6'b1001_10);
        fire(w); check("R5 switch off gives long width", w, LW);
        idle(GAP + 5);

        // R10 held level gives no second pulse
        pulse_starts = 0;
        trig_in = 1; idle(GAP * 3); trig_in = 0; idle(4);
        check("R10 held-high trigger gives one pulse", pulse_starts, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule